// File: doc/BRIEF.md
# Banked Page-Frame Memory Mapper

This block sits on an 8-bit PC-style expansion bus with a 20-bit address. It opens a 64 KB memory window at 0xE0000–0xEFFFF, which is cut into four 16 KB slots. Each slot has its own bank register, and that register chooses which 16 KB block of a larger backing store appears in the slot. A memory cycle that hits the window becomes one byte request on a simple request/done interface to the backing store. The block holds the bus ready line low until that request finishes.

The four bank registers are read and written as I/O ports 0x260–0x263 while the DMA address-enable input is low. All bus strobes are active-low and are sampled on the block clock. Read data is driven from the cycle in which ready is released until the read strobe goes inactive. A memory write does not sample the data bus at once: it waits a fixed number of clocks so that the bus buffers can settle.

Top module: `pgframe_mapper`

## Requirements
- R1: After reset, all four bank registers hold 0, `rdy` is high, `dataOe` is low and `reqValid` is low.
- R2: A memory strobe is handled only when address bits 19:16 equal 0xE. Outside that window there is no request, `rdy` stays high and `dataOe` stays low.
- R3: For a window access, the backing address is {bank[a[15:14]], a[13:0]}. Slot p (base 0xE0000 + p·0x4000) uses the register at I/O port 0x260 + p.
- R4: An I/O cycle is decoded when address bits 11:2 equal 0x098, and bits 1:0 select the register. Other address bits are ignored. A decoded read drives the register value with `dataOe` high from the second clock after the strobe is sampled. An undecoded read drives nothing.
- R5: An I/O write loads the value that was on the data bus in the last clock the write strobe was low. The load happens when the strobe is seen high.
- R6: While `aen` is high, I/O reads and writes have no effect: nothing is driven and the registers do not change.
- R7: For a window access, `rdy` goes low one clock after the strobe is sampled. It stays low until the clock after `reqDone`. I/O and out-of-window cycles never lower `rdy`.
- R8: On a window read, `reqRdata` is captured with `reqDone`. In the next clock `busDataOut` carries that byte, `dataOe` is high and `rdy` is high.
- R9: `dataOe` stays high while the read strobe stays low. It falls one clock after the strobe is sampled high.
- R10: On a window write, the data bus is sampled at the SETTLE-th rising edge after the edge that accepted the strobe. That byte is sent on `reqWdata` with `reqWrite` high.
- R11: Once `reqValid` rises, it stays high and `reqAddr` stays stable until `reqDone` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 20 | Bus address |
| busDataIn | input | 8 | Data bus as seen from the bus |
| busDataOut | output | 8 | Data to drive onto the bus |
| dataOe | output | 1 | Output enable for busDataOut |
| memRdN | input | 1 | Memory read strobe, active low |
| memWrN | input | 1 | Memory write strobe, active low |
| ioRdN | input | 1 | I/O read strobe, active low |
| ioWrN | input | 1 | I/O write strobe, active low |
| aen | input | 1 | DMA address enable; high blocks I/O decode |
| rdy | output | 1 | Bus ready; low inserts wait states |
| reqValid | output | 1 | Backing request pending |
| reqWrite | output | 1 | Pending request is a write |
| reqAddr | output | 22 | Backing byte address |
| reqWdata | output | 8 | Backing write data |
| reqRdata | input | 8 | Backing read data, valid with reqDone |
| reqDone | input | 1 | One-clock completion of the pending request |

## Verification
The assertions rely on the bus protocol being followed. The bus keeps the address and the active strobe steady until the block lowers and then releases `rdy`. Only one strobe is active at a time. The backing store raises `reqDone` only while `reqValid` is high, and for one clock only.

The bench drives every bus cycle from tasks that hold the strobe until `rdy` returns. A responder in the bench answers each request once, after a random latency of 0 to 3 clocks. Random I/O and memory cycles are drawn from $urandom with a fixed seed, and directed cases cover the slot edges, address aliasing and `aen` blocking.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IO_RD,
    ST_IO_WR,
    ST_RD_REQ,
    ST_RD_DRV,
    ST_WR_SET,
    ST_WR_REQ,
    ST_WR_END
  } mapState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchAddr;     // capture slot/port select and form backing address
    logic loadIoData;    // load output byte from a bank register
    logic captureWdata;  // sample the data bus into the write holding register
    logic bankWr;        // commit the holding register to the selected bank
    logic captureRdata;  // load output byte from the backing store
  } dpCtl_t;

endpackage

// File: rtl/pgmap_ctrl.sv
module pgmap_ctrl
  import pgmap_pkg::*;
#(
  parameter int SETTLE = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   memRdN,
  input  logic   memWrN,
  input  logic   ioRdN,
  input  logic   ioWrN,
  input  logic   aen,
  input  logic   winHit,
  input  logic   ioHit,
  input  logic   reqDone,
  output dpCtl_t ctl,
  output logic   rdy,
  output logic   dataOe,
  output logic   reqValid,
  output logic   reqWrite
);

  localparam int CNT_W = (SETTLE < 2) ? 1 : $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE - 1);

  mapState_t   state, stateNext;
  logic [CNT_W-1:0] settleCnt;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (!aen && !ioRdN && ioHit) begin
          ctl.latchAddr  = 1'b1;
          ctl.loadIoData = 1'b1;
          stateNext      = ST_IO_RD;
        end else if (!aen && !ioWrN && ioHit) begin
          ctl.latchAddr    = 1'b1;
          ctl.captureWdata = 1'b1;
          stateNext        = ST_IO_WR;
        end else if (!memRdN && winHit) begin
          ctl.latchAddr = 1'b1;
          stateNext     = ST_RD_REQ;
        end else if (!memWrN && winHit) begin
          ctl.latchAddr = 1'b1;
          stateNext     = ST_WR_SET;
        end
      end
      ST_IO_RD: if (ioRdN) stateNext = ST_IDLE;
      ST_IO_WR: begin
        if (ioWrN) begin
          ctl.bankWr = 1'b1;
          stateNext  = ST_IDLE;
        end else begin
          ctl.captureWdata = 1'b1;
        end
      end
      ST_RD_REQ: begin
        if (reqDone) begin
          ctl.captureRdata = 1'b1;
          stateNext        = ST_RD_DRV;
        end
      end
      ST_RD_DRV: if (memRdN) stateNext = ST_IDLE;
      ST_WR_SET: begin
        if (settleCnt == CNT_LAST) begin
          ctl.captureWdata = 1'b1;
          stateNext        = ST_WR_REQ;
        end
      end
      ST_WR_REQ: if (reqDone) stateNext = ST_WR_END;
      ST_WR_END: if (memWrN) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      settleCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_WR_SET) settleCnt <= settleCnt + 1'b1;
      else                    settleCnt <= '0;
    end
  end

  assign rdy      = !(state == ST_RD_REQ || state == ST_WR_SET || state == ST_WR_REQ);
  assign dataOe   = (state == ST_IO_RD) || (state == ST_RD_DRV);
  assign reqValid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign reqWrite = (state == ST_WR_REQ);

endmodule

// File: rtl/pgmap_dp.sv
module pgmap_dp
  import pgmap_pkg::*;
#(
  parameter int              ADDR_W    = 20,
  parameter int              PAGES     = 4,
  parameter int              PAGE_BITS = 14,
  parameter int              BANK_W    = 8,
  parameter int              DATA_W    = 8,
  parameter logic [19:0]     WIN_BASE  = 20'hE0000,
  parameter logic [11:0]     IO_BASE   = 12'h260
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dpCtl_t                         ctl,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [DATA_W-1:0]              busDataIn,
  input  logic [DATA_W-1:0]              reqRdata,
  output logic                           winHit,
  output logic                           ioHit,
  output logic [DATA_W-1:0]              busDataOut,
  output logic [BANK_W+PAGE_BITS-1:0]    reqAddr,
  output logic [DATA_W-1:0]              reqWdata
);

  localparam int PSEL_W  = $clog2(PAGES);
  localparam int WIN_LSB = PAGE_BITS + PSEL_W;
  localparam int IO_W    = 12;
  localparam int BACK_W  = BANK_W + PAGE_BITS;

  logic [BANK_W-1:0] bankQ [PAGES];
  logic [PSEL_W-1:0] pageSel, ioSelNow, ioSelQ;
  logic [BACK_W-1:0] reqAddrQ;
  logic [DATA_W-1:0] dOutQ, wHoldQ;

  assign pageSel  = busAddr[WIN_LSB-1:PAGE_BITS];
  assign ioSelNow = busAddr[PSEL_W-1:0];
  assign winHit   = (busAddr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);
  assign ioHit    = (busAddr[IO_W-1:PSEL_W] == IO_BASE[IO_W-1:PSEL_W]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < PAGES; p++) bankQ[p] <= '0;
      ioSelQ   <= '0;
      reqAddrQ <= '0;
      dOutQ    <= '0;
      wHoldQ   <= '0;
    end else begin
      if (ctl.latchAddr) begin
        ioSelQ   <= ioSelNow;
        reqAddrQ <= {bankQ[pageSel], busAddr[PAGE_BITS-1:0]};
      end
      if (ctl.loadIoData)        dOutQ <= bankQ[ioSelNow];
      else if (ctl.captureRdata) dOutQ <= reqRdata;
      if (ctl.captureWdata) wHoldQ <= busDataIn;
      if (ctl.bankWr) bankQ[ioSelQ] <= wHoldQ[BANK_W-1:0];
    end
  end

  assign busDataOut = dOutQ;
  assign reqAddr    = reqAddrQ;
  assign reqWdata   = wHoldQ;

endmodule

// File: rtl/pgframe_mapper.sv
module pgframe_mapper
  import pgmap_pkg::*;
#(
  parameter int          ADDR_W    = 20,
  parameter int          PAGES     = 4,
  parameter int          PAGE_BITS = 14,
  parameter int          BANK_W    = 8,
  parameter int          DATA_W    = 8,
  parameter int          SETTLE    = 2,
  parameter logic [19:0] WIN_BASE  = 20'hE0000,
  parameter logic [11:0] IO_BASE   = 12'h260,
  localparam int         BACK_W    = BANK_W + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] busDataOut,
  output logic              dataOe,
  input  logic              memRdN,
  input  logic              memWrN,
  input  logic              ioRdN,
  input  logic              ioWrN,
  input  logic              aen,
  output logic              rdy,
  output logic              reqValid,
  output logic              reqWrite,
  output logic [BACK_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] reqRdata,
  input  logic              reqDone
);

  dpCtl_t ctl;
  logic   winHit, ioHit;

  pgmap_ctrl #(.SETTLE(SETTLE)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN), .aen(aen),
    .winHit(winHit), .ioHit(ioHit), .reqDone(reqDone),
    .ctl(ctl), .rdy(rdy), .dataOe(dataOe), .reqValid(reqValid), .reqWrite(reqWrite)
  );

  pgmap_dp #(
    .ADDR_W(ADDR_W), .PAGES(PAGES), .PAGE_BITS(PAGE_BITS), .BANK_W(BANK_W),
    .DATA_W(DATA_W), .WIN_BASE(WIN_BASE), .IO_BASE(IO_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .busAddr(busAddr), .busDataIn(busDataIn), .reqRdata(reqRdata),
    .winHit(winHit), .ioHit(ioHit), .busDataOut(busDataOut),
    .reqAddr(reqAddr), .reqWdata(reqWdata)
  );

endmodule

// File: rtl/pgframe_mapper_chk.sv
module pgframe_mapper_chk #(
  parameter int BACK_W = 22
) (
  input logic              clk,
  input logic              rstN,
  input logic              memRdN,
  input logic              memWrN,
  input logic              ioRdN,
  input logic              rdy,
  input logic              dataOe,
  input logic              reqValid,
  input logic              reqDone,
  input logic [BACK_W-1:0] reqAddr
);

  AST_REQ_STALLS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !rdy);  // R7

  AST_RDY_ONLY_MEM: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdy) |-> ($past(!memRdN) || $past(!memWrN)));  // R7

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqDone) |=> (reqValid && $stable(reqAddr)));  // R11

  AST_OE_WITH_RDY: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> rdy);  // R8

  AST_OE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && memRdN && ioRdN) |=> !dataOe);  // R9

  AST_OE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> ($past(!memRdN) || $past(!ioRdN)));  // R9

endmodule

bind pgframe_mapper pgframe_mapper_chk #(.BACK_W(BACK_W)) u_chk (
  .clk(clk), .rstN(rstN), .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN),
  .rdy(rdy), .dataOe(dataOe), .reqValid(reqValid), .reqDone(reqDone),
  .reqAddr(reqAddr)
);

// File: tb/pgframe_mapper_tb.sv
module pgframe_mapper_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] busAddr = '0;
  logic [7:0]  busDataIn = '0;
  logic [7:0]  busDataOut;
  logic        dataOe;
  logic        memRdN = 1'b1, memWrN = 1'b1, ioRdN = 1'b1, ioWrN = 1'b1, aen = 1'b0;
  logic        rdy, reqValid, reqWrite;
  logic [21:0] reqAddr;
  logic [7:0]  reqWdata;
  logic [7:0]  reqRdata = '0;
  logic        reqDone = 1'b0;

  int testCount = 0;
  int failCount = 0;
  int reqCount  = 0;
  int reqLat    = 0;
  logic [21:0] lastReqAddr = '0;
  logic        lastReqWrite = 1'b0;
  logic [7:0]  bankModel [4];
  logic [7:0]  mem [int unsigned];
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgframe_mapper #(.SETTLE(SETTLE)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busDataIn(busDataIn),
    .busDataOut(busDataOut), .dataOe(dataOe), .memRdN(memRdN), .memWrN(memWrN),
    .ioRdN(ioRdN), .ioWrN(ioWrN), .aen(aen), .rdy(rdy), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqRdata(reqRdata), .reqDone(reqDone)
  );

  function automatic logic [7:0] fillByte(logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {2'b10, a[21:16]};
  endfunction

  function automatic logic [7:0] memVal(logic [21:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return fillByte(a);
  endfunction

  function automatic bit inWin(logic [19:0] a);
    return a[19:16] == 4'hE;
  endfunction

  function automatic bit ioDec(logic [19:0] a);
    return a[11:2] == 10'h098;
  endfunction

  function automatic logic [21:0] backAddr(logic [19:0] a);
    return {bankModel[a[15:14]], a[13:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // backing-store responder
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk);
      if (reqDone) reqDone = 1'b0;
      else if (reqValid) begin
        if (lat >= reqLat) begin
          reqDone      = 1'b1;
          lastReqAddr  = reqAddr;
          lastReqWrite = reqWrite;
          reqCount++;
          if (reqWrite) mem[int'(reqAddr)] = reqWdata;
          else          reqRdata = memVal(reqAddr);
          lat = 0;
        end else lat++;
      end
    end
  end

  task automatic ioWrite(logic [19:0] a, logic [7:0] d, logic aenV);
    @(negedge clk);
    busAddr = a; busDataIn = ~d; aen = aenV; ioWrN = 1'b0;
    @(negedge clk);
    busDataIn = d;
    chk("R7 io write keeps rdy", 32'(rdy), 32'd1);
    @(negedge clk);
    ioWrN = 1'b1; busDataIn = d ^ 8'h5A;  // R5: only last low-cycle data counts
    @(negedge clk);
    aen = 1'b0;
    if (!aenV && ioDec(a)) bankModel[a[1:0]] = d;
  endtask

  task automatic ioRead(logic [19:0] a, logic aenV, string req);
    bit hit;
    hit = !aenV && ioDec(a);
    @(negedge clk);
    busAddr = a; aen = aenV; ioRdN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk({req, " io read oe"}, 32'(dataOe), 32'(hit));
    if (hit) chk({req, " io read data"}, 32'(busDataOut), 32'(bankModel[a[1:0]]));
    chk("R7 io read keeps rdy", 32'(rdy), 32'd1);
    ioRdN = 1'b1;
    @(negedge clk);
    chk("R9 io oe off", 32'(dataOe), 32'd0);
    aen = 1'b0;
  endtask

  task automatic memRead(logic [19:0] a);
    int c0;
    logic [21:0] firstAddr;
    c0 = reqCount;
    reqLat = int'($urandom % 4);
    @(negedge clk);
    busAddr = a; memRdN = 1'b0;
    @(negedge clk);
    if (inWin(a)) begin
      chk("R7 rdy low on read", 32'(rdy), 32'd0);
      firstAddr = reqAddr;
      for (int i = 0; i < 100 && !rdy; i++) begin
        chk("R11 request held", {8'(reqValid), 24'(reqAddr)}, {8'd1, 24'(firstAddr)});
        @(negedge clk);
      end
      chk("R8 rdy released", 32'(rdy), 32'd1);
      chk("R8 oe with data", 32'(dataOe), 32'd1);
      chk("R3 backing address", 32'(lastReqAddr), 32'(backAddr(a)));
      chk("R8 read data", 32'(busDataOut), 32'(memVal(backAddr(a))));
      @(negedge clk);
      chk("R9 oe held with strobe", 32'(dataOe), 32'd1);
    end else begin
      @(negedge clk);
      chk("R2 outside rdy", 32'(rdy), 32'd1);
      chk("R2 outside oe", 32'(dataOe), 32'd0);
      chk("R2 outside no request", 32'(reqCount), 32'(c0));
    end
    memRdN = 1'b1;
    @(negedge clk);
    chk("R9 oe drops", 32'(dataOe), 32'd0);
  endtask

  task automatic memWrite(logic [19:0] a, logic [7:0] d);
    int c0;
    c0 = reqCount;
    reqLat = int'($urandom % 4);
    @(negedge clk);
    busAddr = a; busDataIn = ~d; memWrN = 1'b0;
    @(negedge clk);
    busDataIn = d;  // settles before the sampling edge
    if (inWin(a)) begin
      chk("R7 rdy low on write", 32'(rdy), 32'd0);
      for (int i = 0; i < 100 && !rdy; i++) @(negedge clk);
      chk("R7 rdy back", 32'(rdy), 32'd1);
      chk("R3 write backing address", 32'(lastReqAddr), 32'(backAddr(a)));
      chk("R10 write request", 32'(lastReqWrite), 32'd1);
      chk("R10 written byte", 32'(memVal(backAddr(a))), 32'(d));
    end else begin
      @(negedge clk);
      chk("R2 outside write rdy", 32'(rdy), 32'd1);
      chk("R2 outside write no request", 32'(reqCount), 32'(c0));
    end
    memWrN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failCount++;
      testCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [19:0] a;
    for (int p = 0; p < 4; p++) bankModel[p] = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset rdy", 32'(rdy), 32'd1);
    chk("R1 reset oe", 32'(dataOe), 32'd0);
    chk("R1 reset req", 32'(reqValid), 32'd0);
    rstN = 1'b1;
    for (int p = 0; p < 4; p++) ioRead(20'h00260 + 20'(p), 1'b0, "R1");

    // directed: program banks, aliasing, undecoded port, aen blocking
    ioWrite(20'h00260, 8'h12, 1'b0);
    ioWrite(20'h00261, 8'h34, 1'b0);
    ioWrite(20'h0F262, 8'h56, 1'b0);  // R4 upper bits ignored
    ioWrite(20'h00263, 8'hFF, 1'b0);
    for (int p = 0; p < 4; p++) ioRead(20'h00260 + 20'(p), 1'b0, "R5");
    ioWrite(20'h00264, 8'hAA, 1'b0);
    ioRead(20'h00264, 1'b0, "R4");
    ioRead(20'h0A263, 1'b0, "R4");
    ioWrite(20'h00262, 8'h99, 1'b1);
    ioRead(20'h00262, 1'b1, "R6");
    ioRead(20'h00262, 1'b0, "R6");

    // directed: slot edges and window edges
    memWrite(20'hE0000, 8'hC1);
    memWrite(20'hE3FFF, 8'hC2);
    memWrite(20'hE4000, 8'hC3);
    memWrite(20'hEFFFF, 8'hC4);
    memRead(20'hE0000);
    memRead(20'hE3FFF);
    memRead(20'hE4000);
    memRead(20'hEFFFF);
    memWrite(20'hDFFFF, 8'h77);
    memWrite(20'hF0000, 8'h77);
    memRead(20'hDFFFF);
    memRead(20'hF0000);
    ioWrite(20'h00260, 8'h34, 1'b0);  // slot 0 now aliases slot 1's block
    memRead(20'hE0000);

    // constrained random mix
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom % 6);
      a = {4'hE, 16'($urandom)};
      if (($urandom % 8) == 0) a = 20'($urandom);
      case (op)
        0: ioWrite(20'h00260 + 20'($urandom % 4), 8'($urandom % 8), 1'(($urandom % 5) == 0));
        1: ioRead(20'h00260 + 20'($urandom % 4), 1'b0, "R4");
        2, 3: memWrite(a, 8'($urandom));
        default: memRead(a);
      endcase
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule